// File: doc/BRIEF.md
# Windowed Performance-Level Governor

This block selects an operating performance level, an index that stands for a paired supply voltage and clock frequency, once per long decision window. A free-running counter divides time into windows of `WINDOW_LEN` cycles. Inside each window the block counts the cycles in which the served engine did work. At the last cycle of the window it forms a demand estimate for the next window: that busy count plus the amount of work still queued. The queued work is the carry-over from a window that ran at too low a level.

The new level is the lowest index whose capacity threshold covers the demand. The goal is to finish the predicted work just in time, not to run fast and then sit idle. The level register changes only at the edge that closes a window. It then holds for the whole next window. A one-cycle strobe marks a boundary at which the index actually moved. After reset the block runs at the top level until it has measured one full window.

Top module: `dvfs_governor`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `level` equals `NUM_LEVELS-1` (the top level) and `levelChange` is 0. Reset also restarts the window counter and clears the busy count, so activity seen before reset does not count.
- R2: Windows are exactly `WINDOW_LEN` cycles long, counted from the first cycle after reset. `level` can only change at the clock edge that ends the last cycle of a window, and it stays constant on every other cycle.
- R3: A cycle counts as busy when `busyIn` is 1, or when `workDone` is 1, or when both are 1. Each cycle adds at most one to the busy count.
- R4: The demand for the next window is the number of busy cycles in the closing window, including its last cycle, plus the value of `pendingWork` in that last cycle.
- R5: The new level is the smallest index i for which `LEVEL_CAP[i]` is greater than or equal to the demand. A demand exactly equal to a threshold selects that threshold's level.
- R6: When the demand is larger than every threshold, the new level is `NUM_LEVELS-1`. This holds up to the largest demand the counts can produce, with no wrap.
- R7: `levelChange` is 1 for exactly the first cycle of a window whose level differs from the previous window's level. It is 0 on every other cycle, including boundaries at which the level is unchanged.
- R8: The busy count starts from zero in every window. Busy cycles from earlier windows never enter a later demand; only `pendingWork` carries work forward.
- R9: The value of `pendingWork` on any cycle other than the last cycle of a window has no effect on the level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busyIn | input | 1 | The served engine is busy this cycle |
| workDone | input | 1 | One-cycle pulse when a unit of work completes |
| pendingWork | input | PEND_W | Queued work still unfinished, in cycles |
| level | output | LVL_W | Performance-level index in force (0 is the slowest) |
| levelChange | output | 1 | One-cycle pulse on the first cycle of a window with a new level |

## Verification
A corrupted busy count or a wrong demand sum does not show until the next boundary. It then appears as a wrong `level` index, so it is visible within at most one window. Each stimulus window is therefore built so that its demand sits on, just under, or just over a threshold; an error of one cycle then moves the index. A window counter that drifts shows up faster: `level` or `levelChange` moves on a cycle other than the first of a window. The bench watches for this on every cycle. Leftover busy counts across windows or across reset show up as a level that is too high after an idle window.

// File: rtl/dvfs_gov_pkg.sv
package dvfs_gov_pkg;

  // Strobes passed from the window control to the demand datapath.
  typedef struct packed {
    logic sampleDemand;  // last cycle of the window: demand is consumed now
    logic clearBusy;     // restart the busy count at the next edge
  } govStrobes_t;

endpackage

// File: rtl/dvfs_gov_dp.sv
module dvfs_gov_dp
  import dvfs_gov_pkg::*;
#(
  parameter int unsigned WINDOW_LEN = 1 << 20,
  parameter int unsigned NUM_LEVELS = 4,
  parameter int unsigned PEND_W     = 16,
  parameter int unsigned LEVEL_CAP [NUM_LEVELS] = '{32'd262144, 32'd524288, 32'd786432, 32'd1048576},
  localparam int unsigned ACC_W = $clog2(WINDOW_LEN + 1),
  localparam int unsigned DEM_W = ((ACC_W > PEND_W) ? ACC_W : PEND_W) + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busyIn,
  input  logic                  workDone,
  input  logic [PEND_W-1:0]     pendingWork,
  input  govStrobes_t           strobes,
  output logic [ACC_W-1:0]      busyAcc,
  output logic [NUM_LEVELS-1:0] fitVec
);

  logic             activeNow;
  logic [DEM_W-1:0] demand;

  // A completion pulse marks a cycle of real work even if the busy flag is low.
  assign activeNow = busyIn | workDone;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyAcc <= '0;
    end else if (strobes.clearBusy) begin
      busyAcc <= '0;
    end else if (activeNow) begin
      busyAcc <= busyAcc + ACC_W'(1);
    end
  end

  // The closing cycle's own activity and the queued work both enter the estimate.
  assign demand = DEM_W'(busyAcc) + DEM_W'(activeNow) + DEM_W'(pendingWork);

  // One comparator per level, each against its own capacity threshold.
  generate
    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_fit
      assign fitVec[g] = (32'(demand) <= LEVEL_CAP[g]);
    end
  endgenerate

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyAcc <= ACC_W'(WINDOW_LEN));

  // R8
  busy_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.sampleDemand |=> (busyAcc <= ACC_W'(1)));

endmodule

// File: rtl/dvfs_gov_ctrl.sv
module dvfs_gov_ctrl
  import dvfs_gov_pkg::*;
#(
  parameter int unsigned WINDOW_LEN = 1 << 20,
  parameter int unsigned NUM_LEVELS = 4,
  localparam int unsigned CNT_W = $clog2(WINDOW_LEN),
  localparam int unsigned LVL_W = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LEVELS-1:0] fitVec,
  output govStrobes_t           strobes,
  output logic [CNT_W-1:0]      winCnt,
  output logic [LVL_W-1:0]      levelQ,
  output logic                  changeQ
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WINDOW_LEN - 1);
  localparam logic [LVL_W-1:0] TOP_LVL  = LVL_W'(NUM_LEVELS - 1);

  logic             winLast;
  logic [LVL_W-1:0] pickLvl;

  assign winLast = (winCnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (winLast) begin
      winCnt <= '0;
    end else begin
      winCnt <= winCnt + CNT_W'(1);
    end
  end

  assign strobes.sampleDemand = winLast;
  assign strobes.clearBusy    = winLast;

  // Lowest fitting level wins; nothing fits -> top level.
  always_comb begin
    pickLvl = TOP_LVL;
    for (int i = NUM_LEVELS - 1; i >= 0; i--) begin
      if (fitVec[i]) pickLvl = LVL_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelQ  <= TOP_LVL;
      changeQ <= 1'b0;
    end else if (winLast) begin
      levelQ  <= pickLvl;
      changeQ <= (pickLvl != levelQ);
    end else begin
      changeQ <= 1'b0;
    end
  end

  // R2
  win_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    winCnt <= LAST_CNT);

  // R2
  level_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !winLast |=> $stable(levelQ));

  // R7
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    winLast && (pickLvl != levelQ) |=> changeQ && (levelQ != $past(levelQ)));

  // R7
  strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !winLast |=> !changeQ);

endmodule

// File: rtl/dvfs_governor.sv
module dvfs_governor
  import dvfs_gov_pkg::*;
#(
  parameter int unsigned WINDOW_LEN = 1 << 20,
  parameter int unsigned NUM_LEVELS = 4,
  parameter int unsigned PEND_W     = 16,
  parameter int unsigned LEVEL_CAP [NUM_LEVELS] = '{32'd262144, 32'd524288, 32'd786432, 32'd1048576},
  localparam int unsigned LVL_W = $clog2(NUM_LEVELS),
  localparam int unsigned CNT_W = $clog2(WINDOW_LEN),
  localparam int unsigned ACC_W = $clog2(WINDOW_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busyIn,
  input  logic              workDone,
  input  logic [PEND_W-1:0] pendingWork,
  output logic [LVL_W-1:0]  level,
  output logic              levelChange
);

  govStrobes_t           strobes;
  logic [NUM_LEVELS-1:0] fitVec;
  logic [ACC_W-1:0]      busyAcc;
  logic [CNT_W-1:0]      winCnt;

  dvfs_gov_dp #(
    .WINDOW_LEN(WINDOW_LEN),
    .NUM_LEVELS(NUM_LEVELS),
    .PEND_W    (PEND_W),
    .LEVEL_CAP (LEVEL_CAP)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .busyIn     (busyIn),
    .workDone   (workDone),
    .pendingWork(pendingWork),
    .strobes    (strobes),
    .busyAcc    (busyAcc),
    .fitVec     (fitVec)
  );

  dvfs_gov_ctrl #(
    .WINDOW_LEN(WINDOW_LEN),
    .NUM_LEVELS(NUM_LEVELS)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .fitVec (fitVec),
    .strobes(strobes),
    .winCnt (winCnt),
    .levelQ (level),
    .changeQ(levelChange)
  );

  // R3: one busy count per elapsed cycle of the window at most
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    ACC_W'(busyAcc) <= ACC_W'(winCnt));

endmodule

// File: tb/dvfs_governor_test.sv
module dvfs_governor_test;

  localparam int WIN  = 40;
  localparam int NLVL = 4;
  localparam int PW   = 8;
  localparam int NVEC = 11;

  // {busy cycles, completion-only cycles, pending in last cycle, pending elsewhere}
  localparam logic [31:0] VECS [NVEC] = '{
    {8'd5,  8'd0, 8'd0,   8'd200},  // 5   -> L0, change from top
    {8'd5,  8'd5, 8'd0,   8'd0},    // 10  -> L0 exactly on threshold, no change
    {8'd8,  8'd2, 8'd1,   8'd0},    // 11  -> L1
    {8'd20, 8'd0, 8'd0,   8'd0},    // 20  -> L1
    {8'd25, 8'd5, 8'd0,   8'd0},    // 30  -> L2
    {8'd30, 8'd5, 8'd6,   8'd0},    // 41  -> L3 above all
    {8'd40, 8'd0, 8'd0,   8'd0},    // 40  -> L3
    {8'd0,  8'd0, 8'd0,   8'd255},  // 0   -> L0, stale pending ignored
    {8'd0,  8'd0, 8'd25,  8'd0},    // 25  -> L2 from carried work only
    {8'd40, 8'd0, 8'd255, 8'd0},    // 295 -> L3 largest demand
    {8'd0,  8'd0, 8'd0,   8'd0}     // 0   -> L0
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busyIn = 1'b0;
  logic          workDone = 1'b0;
  logic [PW-1:0] pendingWork = '0;
  logic [1:0]    level;
  logic          levelChange;

  int total = 0;
  int bad = 0;
  int expLvl = NLVL - 1;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dvfs_governor #(
    .WINDOW_LEN(WIN),
    .NUM_LEVELS(NLVL),
    .PEND_W    (PW),
    .LEVEL_CAP ('{32'd10, 32'd20, 32'd30, 32'd40})
  ) uut (
    .clk        (clk),
    .rstN       (rstN),
    .busyIn     (busyIn),
    .workDone   (workDone),
    .pendingWork(pendingWork),
    .level      (level),
    .levelChange(levelChange)
  );

  function automatic int pickLevel(input int d);
    if (d <= 10) return 0;
    if (d <= 20) return 1;
    if (d <= 30) return 2;
    return 3;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  // Runs one window from its first cycle; returns at the first cycle of the next.
  task automatic runWindow(input int nBusy, input int nDone, input int pLast,
                           input int pOther, input string tag);
    int holdBad = 0;
    int startLvl = level;
    int newLvl;
    for (int i = 0; i < WIN; i++) begin
      busyIn      = (i < nBusy);
      workDone    = (i >= nBusy) && (i < nBusy + nDone);
      pendingWork = PW'((i == WIN - 1) ? pLast : pOther);
      @(posedge clk);
      @(negedge clk);
      if (i < WIN - 1 && (level != startLvl || levelChange)) holdBad++;
    end
    busyIn = 1'b0; workDone = 1'b0; pendingWork = '0;
    check({"R2 hold inside window ", tag}, holdBad, 0);
    newLvl = pickLevel(nBusy + nDone + pLast);
    check({"R3/R4/R5/R6/R9 level ", tag}, level, newLvl);
    check({"R7 strobe ", tag}, levelChange, (newLvl != expLvl) ? 1 : 0);
    expLvl = newLvl;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 reset level", level, NLVL - 1);
    check("R1 reset strobe", levelChange, 0);
    rstN = 1'b1;
    check("R1 level after release", level, NLVL - 1);

    // Table walk: R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < NVEC; v++) begin
      runWindow(int'(VECS[v][31:24]), int'(VECS[v][23:16]),
                int'(VECS[v][15:8]), int'(VECS[v][7:0]), $sformatf("vec%0d", v));
    end

    // Reset in mid-window with heavy activity: R1 restart of count and window
    busyIn = 1'b1;
    repeat (15) begin @(posedge clk); @(negedge clk); end
    rstN = 1'b0;
    repeat (2) begin @(posedge clk); @(negedge clk); end
    check("R1 level under mid-run reset", level, NLVL - 1);
    check("R1 strobe under mid-run reset", levelChange, 0);
    busyIn = 1'b0;
    rstN = 1'b1;
    expLvl = NLVL - 1;
    runWindow(3, 0, 0, 0, "after reset");  // 3 -> L0, stale busy would give L1

    // Two quiet windows: R8 nothing accumulated, R7 no strobe on equal level
    runWindow(0, 0, 0, 0, "idle a");
    runWindow(4, 4, 2, 99, "mixed");  // 10 -> L0 still

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule